// File: doc/BRIEF.md
# Weak Ordering Issue Gate

This block decides when a memory operation can leave a core's operation queue for a memory system that may finish operations in any order. Each request carries a one-bit kind: ordinary data access or synchronization. Data accesses go out with no ordering among themselves. The gate keeps ordering only around synchronization points, using two pieces of state. The first is a count of data accesses that have been issued but have not yet completed. The second is a lock that is held while a synchronization operation is in flight.

The request side uses a valid/ready handshake. The gate stores nothing. When the operation at the head of the queue must wait, the gate holds ready low, so every request behind it waits too. An accepted request appears on the issue output in the same cycle. The memory system reports each completion on a separate strobe and gives the kind of the operation that finished. Completions do not name which data access finished, so data completions may arrive in any order.

Top module: `wo_issue_gate`

## Requirements
- R1: After reset the outstanding count is zero and no synchronization is pending, so a request of either kind is accepted in the first cycle after reset.
- R2: An accepted data request (kind bit 0) raises the outstanding count by one. A data completion (completion kind bit 0) lowers it by one. Data completions may arrive in any order and carry no identity.
- R3: A synchronization request (kind bit 1) is accepted only while the outstanding data count is zero.
- R4: While a synchronization operation is pending, no data request is accepted. A synchronization completion releases the lock from the next cycle on.
- R5: At most one synchronization operation is outstanding. A second synchronization request waits until the first one has completed.
- R6: When a data request is accepted and a data completion arrives in the same cycle, the outstanding count does not change.
- R7: The outstanding count never exceeds the parameter CNT_MAX. While the count is at CNT_MAX, data requests are not accepted.
- R8: The gate has no storage. req_ready is low whenever the head request cannot go, which stalls everything behind it. iss_valid equals req_valid AND req_ready in the same cycle, and iss_is_sync repeats the request's kind bit.
- R9: A data completion that arrives while the count is zero is ignored. A synchronization completion that arrives while no synchronization is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Head of the operation queue is valid |
| req_is_sync | input | 1 | Kind of the head operation: 1 = synchronization, 0 = data |
| req_ready | output | 1 | Head operation is accepted this cycle |
| iss_valid | output | 1 | Operation issued to memory this cycle |
| iss_is_sync | output | 1 | Kind of the issued operation |
| cmp_valid | input | 1 | Memory reports a completion this cycle |
| cmp_is_sync | input | 1 | Kind of the completed operation |

## Verification
The outstanding count cannot be seen at the ports. It shows only through req_ready: for a synchronization request, ready means the count is zero, and for a data request, ready means the count is below CNT_MAX. The hardest case to reach is a count sitting exactly at CNT_MAX or exactly at zero while an issue and a completion fall in the same cycle. The bench reaches it with a small CNT_MAX. It fills the gate with back-to-back data requests, overlaps accepted requests with completions, and then probes the count with a synchronization request and with a stray completion at zero. A long pseudo-random phase follows, and a behavioural model checks ready and the issue outputs in every cycle.

// File: rtl/wo_gate_pkg.sv
// Shared definitions for the weak ordering issue gate.
// Assumes: the kind bit is 0 for data and 1 for synchronization.
package wo_gate_pkg;
    typedef enum logic {
        OP_DATA = 1'b0,
        OP_SYNC = 1'b1
    } op_kind_e;
endpackage

// File: rtl/wo_outstanding_ctr.sv
// Counter of data operations issued but not yet completed.
// Assumes: inc is never raised while at_max is high. A dec while the
// count is zero is dropped, because the operation it names does not exist.
module wo_outstanding_ctr #(
    parameter int CNT_MAX = 15,
    parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_zero,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic dec_ok;

    // Keep only the decrements that have a matching outstanding operation.
    always_comb dec_ok = dec && (cnt_q != '0);

    // Step the count; an increment and a decrement in one cycle cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && !dec_ok) begin
            cnt_q <= cnt_q + ONE;
        end else if (!inc && dec_ok) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Flag the two boundaries that the issue decision looks at.
    always_comb begin
        at_zero = (cnt_q == '0);
        at_max  = (cnt_q == LIMIT);
    end
endmodule

// File: rtl/wo_sync_lock.sv
// Lock that is held from the issue of a synchronization operation until
// its completion.
// Assumes: set and clr never come in the same cycle, because a
// synchronization cannot issue while the lock is held.
module wo_sync_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend_q
);
    // Take the lock on a synchronization issue and release it on its completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set) begin
            pend_q <= 1'b1;
        end else if (clr) begin
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wo_issue_arbiter.sv
// Combinational decision: may the head operation go this cycle?
// Assumes: the head stays stable until it is accepted. Nothing is buffered,
// so a refused head stalls the whole queue.
module wo_issue_arbiter
    import wo_gate_pkg::*;
(
    input  logic     req_valid,
    input  op_kind_e req_kind,
    input  logic     cnt_zero,
    input  logic     cnt_full,
    input  logic     sync_pend,
    output logic     grant,
    output logic     fire_data,
    output logic     fire_sync
);
    // A held lock blocks both kinds. Otherwise a data operation needs room
    // in the count, and a synchronization needs the count drained to zero.
    always_comb begin
        if (sync_pend) begin
            grant = 1'b0;
        end else if (req_kind == OP_SYNC) begin
            grant = cnt_zero;
        end else begin
            grant = !cnt_full;
        end
        fire_data = req_valid && grant && (req_kind == OP_DATA);
        fire_sync = req_valid && grant && (req_kind == OP_SYNC);
    end
endmodule

// File: rtl/wo_issue_gate.sv
// Weak ordering issue gate. Data operations go out freely up to CNT_MAX
// outstanding. A synchronization operation waits for the data count to
// reach zero, then blocks every later operation until it completes.
// Assumes: the request side holds valid and kind stable until ready, and
// the memory system reports exactly one completion per issued operation.
module wo_issue_gate
    import wo_gate_pkg::*;
#(
    parameter int CNT_MAX = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_is_sync,
    output logic req_ready,
    output logic iss_valid,
    output logic iss_is_sync,
    input  logic cmp_valid,
    input  logic cmp_is_sync
);
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    op_kind_e          req_kind;
    op_kind_e          cmp_kind;
    logic              grant;
    logic              fire_data;
    logic              fire_sync;
    logic              cmp_data;
    logic              cmp_sync;
    logic              cnt_zero;
    logic              cnt_full;
    logic              sync_pend;
    logic [CNT_W-1:0]  cnt_now;

    // Turn the raw kind bits into typed values and split completions by kind.
    always_comb begin
        req_kind = op_kind_e'(req_is_sync);
        cmp_kind = op_kind_e'(cmp_is_sync);
        cmp_data = cmp_valid && (cmp_kind == OP_DATA);
        cmp_sync = cmp_valid && (cmp_kind == OP_SYNC) && sync_pend;
    end

    wo_issue_arbiter u_arb (
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .cnt_zero  (cnt_zero),
        .cnt_full  (cnt_full),
        .sync_pend (sync_pend),
        .grant     (grant),
        .fire_data (fire_data),
        .fire_sync (fire_sync)
    );

    wo_outstanding_ctr #(
        .CNT_MAX (CNT_MAX),
        .CNT_W   (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (fire_data),
        .dec     (cmp_data),
        .cnt_q   (cnt_now),
        .at_zero (cnt_zero),
        .at_max  (cnt_full)
    );

    wo_sync_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (fire_sync),
        .clr    (cmp_sync),
        .pend_q (sync_pend)
    );

    // Drive the handshake and the issue outputs from the grant.
    always_comb begin
        req_ready   = grant;
        iss_valid   = fire_data || fire_sync;
        iss_is_sync = fire_sync;
    end
endmodule

// File: rtl/wo_issue_gate_chk.sv
// Checker for the weak ordering issue gate. It is attached by bind and
// watches the ports together with the count and the lock.
module wo_issue_gate_chk #(
    parameter int CNT_MAX = 15,
    parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             iss_valid,
    input logic             iss_is_sync,
    input logic             cmp_valid,
    input logic             cmp_is_sync,
    input logic [CNT_W-1:0] cnt,
    input logic             pend
);
    logic data_iss;
    logic data_cmp;

    // Name the data issue and data completion events once for the properties.
    always_comb begin
        data_iss = iss_valid && !iss_is_sync;
        data_cmp = cmp_valid && !cmp_is_sync;
    end

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_iss && !data_cmp) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R3
    sync_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_is_sync) |-> (cnt == '0));

    // R4
    no_data_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !data_iss);

    // R5
    single_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !(iss_valid && iss_is_sync));

    // R6
    balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_iss && data_cmp && cnt != '0) |=> (cnt == $past(cnt)));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(CNT_MAX));

    // R8
    handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid == (req_valid && req_ready));

    // R9
    stray_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_cmp && !data_iss && cnt == '0) |=> (cnt == '0));
endmodule

bind wo_issue_gate wo_issue_gate_chk #(
    .CNT_MAX (CNT_MAX),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .iss_valid   (iss_valid),
    .iss_is_sync (iss_is_sync),
    .cmp_valid   (cmp_valid),
    .cmp_is_sync (cmp_is_sync),
    .cnt         (cnt_now),
    .pend        (sync_pend)
);

// File: tb/wo_issue_gate_test.sv
// Bench: a behavioural model (integer count, pending bit) checked every cycle.
module wo_issue_gate_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC       = 4;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_is_sync = 1'b0;
    logic cmp_valid = 1'b0;
    logic cmp_is_sync = 1'b0;
    logic req_ready;
    logic iss_valid;
    logic iss_is_sync;

    int checks = 0;
    int failures = 0;
    int m_cnt = 0;
    bit m_pend = 1'b0;
    bit done = 1'b0;
    int cycles = 0;

    wo_issue_gate #(.CNT_MAX(MAXC)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_is_sync (req_is_sync),
        .req_ready   (req_ready),
        .iss_valid   (iss_valid),
        .iss_is_sync (iss_is_sync),
        .cmp_valid   (cmp_valid),
        .cmp_is_sync (cmp_is_sync)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input string tag, input bit v, input bit s, input bit cv, input bit cs);
        bit e_rdy;
        bit fire;
        @(negedge clk);
        req_valid = v; req_is_sync = s; cmp_valid = cv; cmp_is_sync = cs;
        #1;
        e_rdy = m_pend ? 1'b0 : (s ? (m_cnt == 0) : (m_cnt < MAXC));
        fire  = v && e_rdy;
        check(tag, "req_ready", int'(req_ready), int'(e_rdy));
        check(tag, "iss_valid", int'(iss_valid), int'(fire));
        if (fire) check(tag, "iss_is_sync", int'(iss_is_sync), int'(s));
        if (fire && !s) m_cnt++;
        if (cv && !cs && (m_cnt - ((fire && !s) ? 1 : 0)) > 0) m_cnt--;
        if (fire && s) m_pend = 1'b1;
        else if (cv && cs && m_pend) m_pend = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: both kinds are accepted right after reset
        step("R1", 1'b1, 1'b1, 1'b0, 1'b0);
        step("R4", 1'b1, 1'b0, 1'b0, 1'b0);   // data blocked by that sync
        step("R5", 1'b1, 1'b1, 1'b0, 1'b0);   // second sync blocked
        step("R4", 1'b0, 1'b0, 1'b1, 1'b1);   // sync completes
        step("R1", 1'b1, 1'b0, 1'b0, 1'b0);   // data goes again
        // R2, R3: build up three outstanding data ops; sync waits
        step("R2", 1'b1, 1'b0, 1'b0, 1'b0);
        step("R2", 1'b1, 1'b0, 1'b0, 1'b0);
        step("R3", 1'b1, 1'b1, 1'b1, 1'b0);
        step("R3", 1'b1, 1'b1, 1'b1, 1'b0);
        step("R3", 1'b1, 1'b1, 1'b1, 1'b0);
        step("R3", 1'b1, 1'b1, 1'b0, 1'b0);   // count zero: accepted
        step("R9", 1'b0, 1'b0, 1'b1, 1'b0);   // stray data completion
        step("R4", 1'b1, 1'b0, 1'b1, 1'b1);   // still locked this cycle
        step("R9", 1'b0, 1'b0, 1'b1, 1'b1);   // stray sync completion
        step("R9", 1'b1, 1'b1, 1'b0, 1'b0);   // sync sees zero
        step("R4", 1'b0, 1'b0, 1'b1, 1'b1);
        // R7: fill to the limit
        for (int i = 0; i < MAXC; i++) step("R7", 1'b1, 1'b0, 1'b0, 1'b0);
        step("R7", 1'b1, 1'b0, 1'b0, 1'b0);   // full: stalls
        step("R8", 1'b1, 1'b0, 1'b1, 1'b0);   // full + completion: still refused
        // R6: overlap issue and completion, then drain and probe for zero
        step("R6", 1'b1, 1'b0, 1'b1, 1'b0);
        step("R6", 1'b1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < MAXC; i++) step("R6", 1'b1, 1'b1, 1'b1, 1'b0);
        step("R6", 1'b1, 1'b1, 1'b0, 1'b0);
        step("R5", 1'b0, 1'b0, 1'b1, 1'b1);
        // R9: completion at zero together with a data issue
        step("R9", 1'b1, 1'b0, 1'b1, 1'b0);
        step("R9", 1'b1, 1'b1, 1'b0, 1'b0);   // count is 1: sync refused
        step("R9", 1'b0, 1'b0, 1'b1, 1'b0);
        step("R9", 1'b1, 1'b1, 1'b0, 1'b0);
        step("R9", 1'b0, 1'b0, 1'b1, 1'b1);
        // R8: pseudo-random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            bit v  = ($urandom % 4) != 0;
            bit s  = ($urandom % 6) == 0;
            bit cv = ($urandom % 3) != 0;
            bit cs = m_pend ? (($urandom % 2) == 0) : 1'b0;
            step("R8", v, s, cv, cs);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end
endmodule